// File: doc/BRIEF.md
# Parking Bus Arbiter for a Bridge-Side PCI Segment

This block decides which master owns a PCI segment behind a bridge. There are five external masters, each with an active-low request and grant pair. The bridge itself is a sixth requester. The bridge requests the bus in two cases: when it has accepted a transaction from the upstream link that must be forwarded onto the segment, or when a hot-plug command needs the hot-plug controller to own the segment. Masters that are requesting are served in round-robin order.

When no master requests the bus, one grant stays asserted so that the bus never floats. This parked grant goes either to the bridge or to a default external master, chosen by a configuration bit. A per-pair enable mask removes pairs that cannot be used in restricted bus modes. In the fastest bus mode, a programmable run of idle cycles raises a low-power indication. An external-arbiter input switches off every grant this block drives, so that an outside arbiter can take over.

Top module: `pci_park_arb`

## Requirements
- R1: External pair i uses bit i of `req_ni` and `gnt_no`, and both are active low (0 = asserted). The bridge request is `fwd_req_i` OR `hp_req_i`, and it is granted on `host_gnt_o` (1 = granted).
- R2: Grants are registered. When all grants are off, the chosen target is granted at the next clock. When a different grant is on, the target is granted two clocks later.
- R3: At most one of the six grants is asserted in any cycle.
- R4: When the grant moves from one master to another, at least one clock with every grant off lies between the two.
- R5: Arbitration is round-robin over slots 0..4 (the external pairs) and slot 5 (the bridge). The search starts at a pointer. After reset the pointer is 0. Each clock that issues or holds a grant for a requesting slot moves the pointer to the slot after that one. If other slots are also requesting, the current owner loses its grant.
- R6: When no enabled request is active, the bus parks. It parks on the bridge when `cfg_park_host_i`=1. Otherwise it parks on external pair 0, or on the bridge if pair 0 is disabled.
- R7: A pair with `cfg_pair_en_i[i]`=0 is ignored as a requester. It is never granted on the clock after its enable was 0, and a grant it already holds is withdrawn.
- R8: With `ext_arb_i`=1, every grant is off from the next clock onward. The grants resume once the input drops.
- R9: With `cfg_fast_mode_i`=1, `lp_o` rises on the clock that completes `cfg_idle_limit_i` consecutive idle cycles, where a limit of 0 acts as 1. With `cfg_fast_mode_i`=0, `lp_o` stays 0.
- R10: Any active enabled request clears the idle count, and `lp_o` drops on the next clock.
- R11: While `rst_ni`=0, all grants are off and `lp_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_ni | input | 5 | External requests, active low |
| fwd_req_i | input | 1 | Bridge has an upstream transaction to forward |
| hp_req_i | input | 1 | Hot-plug controller needs the segment |
| ext_arb_i | input | 1 | External-arbiter mode: turn off all grants |
| cfg_park_host_i | input | 1 | Park on the bridge when set |
| cfg_pair_en_i | input | 5 | Usable-pair mask for the current bus mode |
| cfg_fast_mode_i | input | 1 | Highest-speed mode, enables the low-power counter |
| cfg_idle_limit_i | input | 8 | Idle cycles before low-power entry |
| gnt_no | output | 5 | External grants, active low |
| host_gnt_o | output | 1 | Grant to the bridge |
| lp_o | output | 1 | Low-power indication |

## Verification
The grant register updates on the first edge after a stimulus when the bus is free. A move between masters takes two edges, with the dead cycle visible after the first. The low-power flag appears on the edge that completes the programmed idle run and clears one edge after a request. The bench drives inputs 1 ns after an edge, waits an exact number of edges, and samples 1 ns after the last one. Each table vector allows three edges, which settles any single-requester transition, and the rotation and timer tests check every intermediate edge.

// File: rtl/pci_arb_pkg.sv
package pci_arb_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD  = 2'd0,
    STEP_DROP  = 2'd1,
    STEP_ISSUE = 2'd2
  } gnt_step_e;
endpackage

// File: rtl/pci_rr_pick.sv
module pci_rr_pick #(
  parameter int unsigned N  = 6,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] ptr_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o
);
  logic [IW:0] sum;

  // scan from farthest to nearest so the nearest requester wins
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    sum   = '0;
    for (int off = N - 1; off >= 0; off--) begin
      sum = {1'b0, ptr_i} + (IW + 1)'(off);
      if (sum >= (IW + 1)'(N)) sum = sum - (IW + 1)'(N);
      if (req_i[sum[IW-1:0]]) begin
        hit_o = 1'b1;
        idx_o = sum[IW-1:0];
      end
    end
  end
endmodule

// File: rtl/pci_idle_timer.sv
module pci_idle_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         busy_i,
  input  logic [W-1:0] limit_i,
  output logic         lp_o
);
  logic [W-1:0] cnt_q;
  logic         lp_q;
  logic [W:0]   cnt_nxt;

  assign cnt_nxt = {1'b0, cnt_q} + (W + 1)'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lp_q  <= 1'b0;
    end else if (!en_i || busy_i) begin
      cnt_q <= '0;
      lp_q  <= 1'b0;
    end else begin
      if (!lp_q) cnt_q <= cnt_nxt[W-1:0];
      lp_q <= lp_q | (cnt_nxt >= {1'b0, limit_i});
    end
  end

  assign lp_o = lp_q;
endmodule

// File: rtl/pci_park_arb.sv
module pci_park_arb
  import pci_arb_pkg::*;
#(
  parameter int unsigned NUM_EXT  = 5,
  parameter int unsigned PARK_EXT = 0,
  parameter int unsigned IDLE_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EXT-1:0] req_ni,
  input  logic               fwd_req_i,
  input  logic               hp_req_i,
  input  logic               ext_arb_i,
  input  logic               cfg_park_host_i,
  input  logic [NUM_EXT-1:0] cfg_pair_en_i,
  input  logic               cfg_fast_mode_i,
  input  logic [IDLE_W-1:0]  cfg_idle_limit_i,
  output logic [NUM_EXT-1:0] gnt_no,
  output logic               host_gnt_o,
  output logic               lp_o
);
  localparam int unsigned NUM_REQ  = NUM_EXT + 1;
  localparam int unsigned IW       = $clog2(NUM_REQ);
  localparam int unsigned HOST_IDX = NUM_EXT;

  logic [NUM_REQ-1:0] req_vec, gnt_q, tgt_oh;
  logic [IW-1:0]      ptr_q, pick_idx, park_idx, tgt_idx, ptr_nxt;
  logic               hit;
  gnt_step_e          step;

  assign req_vec = {fwd_req_i | hp_req_i, ~req_ni & cfg_pair_en_i};

  pci_rr_pick #(.N(NUM_REQ), .IW(IW)) i_pick (
    .req_i (req_vec),
    .ptr_i (ptr_q),
    .hit_o (hit),
    .idx_o (pick_idx)
  );

  assign park_idx = (cfg_park_host_i || !cfg_pair_en_i[PARK_EXT]) ? IW'(HOST_IDX) : IW'(PARK_EXT);
  assign tgt_idx  = hit ? pick_idx : park_idx;
  assign tgt_oh   = NUM_REQ'(1) << tgt_idx;
  assign ptr_nxt  = (tgt_idx == IW'(NUM_REQ - 1)) ? '0 : IW'(tgt_idx + 1'b1);

  always_comb begin
    if (ext_arb_i)             step = STEP_DROP;
    else if (gnt_q == tgt_oh)  step = STEP_HOLD;
    else if (gnt_q != '0)      step = STEP_DROP;
    else                       step = STEP_ISSUE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q <= '0;
      ptr_q <= '0;
    end else begin
      unique case (step)
        STEP_DROP:  gnt_q <= '0;
        STEP_ISSUE: gnt_q <= tgt_oh;
        default:    gnt_q <= gnt_q;
      endcase
      // parking does not move the rotation
      if (step != STEP_DROP && hit) ptr_q <= ptr_nxt;
    end
  end

  for (genvar i = 0; i < NUM_EXT; i++) begin : g_gnt
    assign gnt_no[i] = ~gnt_q[i];
  end
  assign host_gnt_o = gnt_q[HOST_IDX];

  pci_idle_timer #(.W(IDLE_W)) i_idle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (cfg_fast_mode_i),
    .busy_i  (hit),
    .limit_i (cfg_idle_limit_i),
    .lp_o    (lp_o)
  );
endmodule

// File: rtl/pci_park_arb_chk.sv
module pci_park_arb_chk #(
  parameter int unsigned NUM_EXT = 5,
  parameter int unsigned IDLE_W  = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_EXT-1:0] req_ni,
  input logic               fwd_req_i,
  input logic               hp_req_i,
  input logic               ext_arb_i,
  input logic [NUM_EXT-1:0] cfg_pair_en_i,
  input logic               cfg_fast_mode_i,
  input logic [IDLE_W-1:0]  cfg_idle_limit_i,
  input logic [NUM_EXT-1:0] gnt_no,
  input logic               host_gnt_o,
  input logic               lp_o
);
  logic [NUM_EXT:0] all_g;
  logic             busy;

  assign all_g = {host_gnt_o, ~gnt_no};
  assign busy  = (|(~req_ni & cfg_pair_en_i)) | fwd_req_i | hp_req_i;

  assert_onehot_grant_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(all_g));

  assert_dead_cycle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (all_g != '0 && $past(all_g) != '0) |-> all_g == $past(all_g));

  for (genvar i = 0; i < NUM_EXT; i++) begin : g_mask
    assert_masked_pair_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !gnt_no[i] |-> $past(cfg_pair_en_i[i]));
  end

  assert_ext_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_arb_i |=> all_g == '0);

  assert_lp_mode_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_fast_mode_i |=> !lp_o);

  assert_lp_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> !lp_o);
endmodule

bind pci_park_arb pci_park_arb_chk #(.NUM_EXT(NUM_EXT), .IDLE_W(IDLE_W)) i_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .req_ni           (req_ni),
  .fwd_req_i        (fwd_req_i),
  .hp_req_i         (hp_req_i),
  .ext_arb_i        (ext_arb_i),
  .cfg_pair_en_i    (cfg_pair_en_i),
  .cfg_fast_mode_i  (cfg_fast_mode_i),
  .cfg_idle_limit_i (cfg_idle_limit_i),
  .gnt_no           (gnt_no),
  .host_gnt_o       (host_gnt_o),
  .lp_o             (lp_o)
);

// File: tb/test_pci_park_arb.sv
`timescale 1ns/1ps
module test_pci_park_arb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] req_ni = 5'h1f;
  logic       fwd_req_i = 1'b0, hp_req_i = 1'b0, ext_arb_i = 1'b0;
  logic       cfg_park_host_i = 1'b0, cfg_fast_mode_i = 1'b0;
  logic [4:0] cfg_pair_en_i = 5'h1f;
  logic [7:0] cfg_idle_limit_i = 8'd4;
  logic [4:0] gnt_no;
  logic       host_gnt_o, lp_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  pci_park_arb i_pci_park_arb (
    .clk_i, .rst_ni, .req_ni, .fwd_req_i, .hp_req_i, .ext_arb_i,
    .cfg_park_host_i, .cfg_pair_en_i, .cfg_fast_mode_i, .cfg_idle_limit_i,
    .gnt_no, .host_gnt_o, .lp_o
  );

  // vector: req_n, fwd, hp, park_host, pair_en, exp gnt_n, exp host
  localparam logic [18:0] VEC [0:7] = '{
    {5'b11111, 1'b0, 1'b0, 1'b0, 5'b11111, 5'b11110, 1'b0},  // R6 park on pair 0
    {5'b11111, 1'b0, 1'b0, 1'b1, 5'b11111, 5'b11111, 1'b1},  // R6 park on host
    {5'b11011, 1'b0, 1'b0, 1'b1, 5'b11111, 5'b11011, 1'b0},  // R1 pair 2
    {5'b11111, 1'b1, 1'b0, 1'b0, 5'b11111, 5'b11111, 1'b1},  // R1 forward cause
    {5'b11111, 1'b0, 1'b1, 1'b0, 5'b11111, 5'b11111, 1'b1},  // R1 hot-plug cause
    {5'b01111, 1'b0, 1'b0, 1'b0, 5'b01111, 5'b11110, 1'b0},  // R7 masked request parks
    {5'b11111, 1'b0, 1'b0, 1'b0, 5'b11110, 5'b11111, 1'b1},  // R6 default pair masked
    {5'b11101, 1'b0, 1'b0, 1'b0, 5'b11111, 5'b11101, 1'b0}   // R1 pair 1
  };

  function automatic logic [5:0] grants();
    return {host_gnt_o, ~gnt_no};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    req_ni = 5'h1f; fwd_req_i = 0; hp_req_i = 0; ext_arb_i = 0;
    cfg_park_host_i = 0; cfg_pair_en_i = 5'h1f; cfg_fast_mode_i = 0; cfg_idle_limit_i = 8'd4;
    step(2);
    check("R11 grants in reset", {26'd0, grants()}, 32'd0);
    check("R11 lp in reset", {31'd0, lp_o}, 32'd0);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    do_reset();
    step(1);
    check("R2 R6 park after reset", {27'd0, gnt_no}, {27'd0, 5'b11110});

    for (int v = 0; v < 8; v++) begin
      {req_ni, fwd_req_i, hp_req_i, cfg_park_host_i, cfg_pair_en_i} = VEC[v][18:6];
      step(3);
      check("R1 R6 R7 table grant", {26'd0, host_gnt_o, gnt_no}, {26'd0, VEC[v][0], VEC[v][5:1]});
      check("R9 table lp", {31'd0, lp_o}, 32'd0);
    end

    // R4 R2: move between masters passes through a dead cycle
    do_reset(); step(1);
    req_ni = 5'b11011; step(1);
    check("R4 dead cycle", {26'd0, grants()}, 32'd0);
    step(1);
    check("R2 pair 2 granted", {26'd0, grants()}, 32'h04);
    req_ni = 5'b10111; step(1);
    check("R4 dead cycle 2", {26'd0, grants()}, 32'd0);
    step(1);
    check("R2 pair 3 granted", {26'd0, grants()}, 32'h08);

    // R7: withdraw grant from a pair that gets masked
    cfg_pair_en_i = 5'b10111; step(1);
    check("R7 masked grant withdrawn", {26'd0, grants()}, 32'd0);
    step(1);
    check("R7 park after mask", {26'd0, grants()}, 32'h01);

    // R5: rotation pair 0 -> pair 2 -> host -> pair 0
    do_reset(); step(1);
    req_ni = 5'b11010; fwd_req_i = 1'b1;
    begin
      logic [5:0] exp_seq [0:6] = '{6'h01, 6'h00, 6'h04, 6'h00, 6'h20, 6'h00, 6'h01};
      for (int e = 0; e < 7; e++) begin
        step(1);
        check("R5 rotation", {26'd0, grants()}, {26'd0, exp_seq[e]});
      end
    end

    // R8: external-arbiter mode
    do_reset(); step(1);
    req_ni = 5'b11011; step(2);
    ext_arb_i = 1'b1; step(1);
    check("R8 grants off", {26'd0, grants()}, 32'd0);
    step(3);
    check("R8 grants stay off", {26'd0, grants()}, 32'd0);
    ext_arb_i = 1'b0; step(1);
    check("R8 grants resume", {26'd0, grants()}, 32'h04);

    // R9 R10: idle counter
    req_ni = 5'b11101; step(2);
    req_ni = 5'h1f; cfg_fast_mode_i = 1'b1; cfg_idle_limit_i = 8'd4;
    step(3);
    check("R9 lp before limit", {31'd0, lp_o}, 32'd0);
    step(1);
    check("R9 lp at limit", {31'd0, lp_o}, 32'd1);
    req_ni = 5'b11101; step(1);
    check("R10 lp cleared", {31'd0, lp_o}, 32'd0);
    cfg_idle_limit_i = 8'd0; req_ni = 5'h1f; step(1);
    check("R9 limit zero as one", {31'd0, lp_o}, 32'd1);
    hp_req_i = 1'b1; step(1);
    check("R10 internal request clears lp", {31'd0, lp_o}, 32'd0);
    hp_req_i = 1'b0; cfg_fast_mode_i = 1'b0; step(20);
    check("R9 no lp outside fast mode", {31'd0, lp_o}, 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule